// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns memory READ and WRITE commands into a stream of column addresses, one per clock, for a DDR-style memory controller. It holds its own small mode register, written by a load-mode command that carries a bank-select field and an address word. The register fixes how many beats a burst has (2, 4 or 8), the order in which columns are visited (sequential or interleaved), and the read latency that is reported to the data path. Any reserved encoding in a load is flagged and leaves the previous setting in force.

Every burst stays inside an aligned block of columns whose size equals the burst length. The upper column bits come from the start column and are held for the whole burst; the low bits start at the start column's offset and then advance. In sequential order they count up and wrap at the block edge; in interleaved order they are the start offset XOR the beat index. A new command that arrives during a burst cuts it short and the new burst starts on the next cycle.

The control is a two-state machine. State IDLE (no burst) moves to BURST on an accepted command (transition GO). BURST stays in BURST while beats remain (STEP), returns to BURST at beat 0 when a new command is accepted (RESTART), and returns to IDLE after the last beat (DONE). A command before any valid mode load is refused (REFUSE) and leaves the machine in IDLE.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, busy, cmd_reject, mode_valid and mode_err are 0 and rd_lat is 0.
- R2: A load with cmd_bank = 00 and a legal word updates the mode one cycle later and sets mode_valid = 1, mode_err = 0. Word bits 2..0: 001 = 2 beats, 010 = 4, 011 = 8; bit 3: 0 = sequential, 1 = interleaved; bits 6..4: 010 gives rd_lat = 0 (2 clocks), 110 gives rd_lat = 1 (2.5 clocks); bits above 6 must be all zero, or have only bit 8 set (DLL reset, otherwise treated as normal).
- R3: A load with cmd_bank = 00 whose length, latency or upper-bit field holds any other value sets mode_err = 1 one cycle later and keeps the previous mode and mode_valid.
- R4: A load with cmd_bank other than 00 changes neither the mode, mode_valid nor mode_err.
- R5: While mode_valid = 0, a READ or WRITE is refused: cmd_reject is 1 for the next cycle and busy stays 0.
- R6: An accepted command makes busy 1 from the next cycle for exactly the programmed number of beats; the first beat's col_out equals cmd_col.
- R7: In sequential order, beat i has low bits (start + i) modulo the burst length; the column bits above the block are held for the whole burst.
- R8: In interleaved order, beat i has low bits (start XOR i); upper bits as in R7.
- R9: WRITE bursts follow the same length and order as READ bursts; beat_write is 1 during a WRITE burst and 0 during a READ burst; when cmd_rd and cmd_wr are both high the command is a READ.
- R10: A command accepted while a burst runs ends it; the next cycle shows beat 0 of the new burst, which then runs its full length.
- R11: A mode load during a burst does not change the running burst's length or order; it applies to the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Load-mode command strobe |
| cmd_bank | input | BANK_W | Bank-select field of the load |
| cmd_addr | input | MODE_W | Mode word of the load |
| cmd_rd | input | 1 | READ command strobe |
| cmd_wr | input | 1 | WRITE command strobe |
| cmd_col | input | COL_W | Start column of READ/WRITE |
| col_out | output | COL_W | Column address of the current beat (0 when idle) |
| busy | output | 1 | A beat is being issued this cycle |
| beat_write | output | 1 | Current burst is a WRITE |
| cmd_reject | output | 1 | Previous cycle's command was refused |
| mode_valid | output | 1 | A legal mode has been loaded |
| mode_err | output | 1 | Last base-register load held a reserved code |
| rd_lat | output | 2 | Read latency code: 0 = 2 clocks, 1 = 2.5 clocks |

## Verification
The bench builds the block with a 6-bit column and the default 13-bit mode word, so random start columns often fall in the topmost aligned block and at all-ones offsets, where a wrap bug would spill into the neighbouring block or past the top column. The 13-bit word leaves six upper bits, enough to reach the DLL-reset value, single stray bits and bit 7 alone among the reserved values. Random mode loads switch length and order between bursts, so every length is met in both orders and from every start offset.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    // burst length selector: beats = 2 << len_sel
    typedef enum logic [1:0] {
        LEN_2 = 2'd0,
        LEN_4 = 2'd1,
        LEN_8 = 2'd2
    } len_sel_t;

    typedef struct packed {
        logic     valid;
        len_sel_t len_sel;
        logic     interleave;
        logic     half_lat;
    } mode_cfg_t;

    localparam int unsigned MAX_LEN_LOG = 3;

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int unsigned MODE_W = 13,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] bank,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              err
);

    localparam int unsigned OP_W = MODE_W - 7;
    localparam logic [OP_W-1:0] OP_NORMAL  = '0;
    localparam logic [OP_W-1:0] OP_DLL_RST = OP_W'(2);

    logic [2:0]      len_code;
    logic [2:0]      lat_code;
    logic [OP_W-1:0] op_code;
    logic            len_ok;
    logic            lat_ok;
    logic            op_ok;
    logic            base_sel;
    len_sel_t        len_dec;
    logic            lat_dec;

    assign len_code = word[2:0];
    assign lat_code = word[6:4];
    assign op_code  = word[MODE_W-1:7];
    assign base_sel = (bank == '0);

    always_comb begin
        len_ok  = 1'b1;
        len_dec = LEN_2;
        unique case (len_code)
            3'b001:  len_dec = LEN_2;
            3'b010:  len_dec = LEN_4;
            3'b011:  len_dec = LEN_8;
            default: len_ok  = 1'b0;
        endcase
    end

    always_comb begin
        lat_ok  = 1'b1;
        lat_dec = 1'b0;
        unique case (lat_code)
            3'b010:  lat_dec = 1'b0;
            3'b110:  lat_dec = 1'b1;
            default: lat_ok  = 1'b0;
        endcase
    end

    assign op_ok = (op_code == OP_NORMAL) || (op_code == OP_DLL_RST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{valid: 1'b0, len_sel: LEN_2, interleave: 1'b0, half_lat: 1'b0};
            err <= 1'b0;
        end else if (load && base_sel) begin
            if (len_ok && lat_ok && op_ok) begin
                cfg.valid      <= 1'b1;
                cfg.len_sel    <= len_dec;
                cfg.interleave <= word[3];
                cfg.half_lat   <= lat_dec;
                err            <= 1'b0;
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcs_beat_fsm.sv
module bcs_beat_fsm
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_write,
    input  logic [COL_W-1:0] go_col,
    input  len_sel_t         cfg_len,
    input  logic             cfg_itlv,
    output logic             busy,
    output logic             is_write,
    output logic [COL_W-1:0] start_col,
    output len_sel_t         len_sel,
    output logic             itlv,
    output logic [MAX_LEN_LOG-1:0] beat
);

    seq_state_t             state_q, state_d;
    logic [MAX_LEN_LOG-1:0] beat_q, beat_d;
    logic [MAX_LEN_LOG-1:0] last_beat;
    logic [COL_W-1:0]       col_q, col_d;
    len_sel_t               len_q, len_d;
    logic                   itlv_q, itlv_d;
    logic                   wr_q, wr_d;

    always_comb begin
        unique case (len_q)
            LEN_2:   last_beat = 3'd1;
            LEN_4:   last_beat = 3'd3;
            default: last_beat = 3'd7;
        endcase
    end

    // next-state and next-burst process
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        col_d   = col_q;
        len_d   = len_q;
        itlv_d  = itlv_q;
        wr_d    = wr_q;
        if (go) begin
            // GO from IDLE, RESTART from BURST
            state_d = ST_BURST;
            beat_d  = '0;
            col_d   = go_col;
            len_d   = cfg_len;
            itlv_d  = cfg_itlv;
            wr_d    = go_write;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_BURST: begin
                    if (beat_q == last_beat) begin
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end else begin
                        beat_d  = beat_q + 3'd1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            col_q   <= '0;
            len_q   <= LEN_2;
            itlv_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            col_q   <= col_d;
            len_q   <= len_d;
            itlv_q  <= itlv_d;
            wr_q    <= wr_d;
        end
    end

    // output process
    always_comb begin
        busy      = (state_q == ST_BURST);
        is_write  = busy & wr_q;
        start_col = col_q;
        len_sel   = len_q;
        itlv      = itlv_q;
        beat      = beat_q;
    end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic                   en,
    input  logic [COL_W-1:0]       start_col,
    input  len_sel_t               len_sel,
    input  logic                   itlv,
    input  logic [MAX_LEN_LOG-1:0] beat,
    output logic [COL_W-1:0]       col
);

    logic [COL_W-1:0] cand [MAX_LEN_LOG];

    // one candidate per block size: 2, 4, 8 columns
    for (genvar g = 0; g < MAX_LEN_LOG; g++) begin : g_len
        localparam int unsigned LW = g + 1;
        logic [LW-1:0] off_seq;
        logic [LW-1:0] off_xor;
        assign off_seq = start_col[LW-1:0] + beat[LW-1:0];
        assign off_xor = start_col[LW-1:0] ^ beat[LW-1:0];
        assign cand[g] = {start_col[COL_W-1:LW], (itlv ? off_xor : off_seq)};
    end

    always_comb begin
        col = '0;
        if (en) begin
            unique case (len_sel)
                LEN_2:   col = cand[0];
                LEN_4:   col = cand[1];
                default: col = cand[2];
            endcase
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W  = 10,
    parameter int unsigned MODE_W = 13,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [MODE_W-1:0] cmd_addr,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [COL_W-1:0]  cmd_col,
    output logic [COL_W-1:0]  col_out,
    output logic              busy,
    output logic              beat_write,
    output logic              cmd_reject,
    output logic              mode_valid,
    output logic              mode_err,
    output logic [1:0]        rd_lat
);

    mode_cfg_t              cfg;
    logic                   cmd_any;
    logic                   cmd_go;
    logic                   go_write;
    logic [COL_W-1:0]       start_col;
    len_sel_t               run_len;
    logic                   run_itlv;
    logic [MAX_LEN_LOG-1:0] beat;
    logic                   reject_q;

    assign cmd_any  = cmd_rd | cmd_wr;
    assign cmd_go   = cmd_any & cfg.valid;
    assign go_write = cmd_wr & ~cmd_rd;

    bcs_mode_reg #(.MODE_W(MODE_W), .BANK_W(BANK_W)) u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cmd_load),
        .bank (cmd_bank),
        .word (cmd_addr),
        .cfg  (cfg),
        .err  (mode_err)
    );

    bcs_beat_fsm #(.COL_W(COL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (cmd_go),
        .go_write (go_write),
        .go_col   (cmd_col),
        .cfg_len  (cfg.len_sel),
        .cfg_itlv (cfg.interleave),
        .busy     (busy),
        .is_write (beat_write),
        .start_col(start_col),
        .len_sel  (run_len),
        .itlv     (run_itlv),
        .beat     (beat)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .en       (busy),
        .start_col(start_col),
        .len_sel  (run_len),
        .itlv     (run_itlv),
        .beat     (beat),
        .col      (col_out)
    );

    // REFUSE: command seen before any legal mode load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject_q <= 1'b0;
        end else begin
            reject_q <= cmd_any & ~cfg.valid;
        end
    end

    assign cmd_reject = reject_q;
    assign mode_valid = cfg.valid;
    assign rd_lat     = {1'b0, cfg.half_lat};

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int unsigned COL_W  = 10,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_load,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              cmd_rd,
    input logic              cmd_wr,
    input logic [COL_W-1:0]  cmd_col,
    input logic [COL_W-1:0]  col_out,
    input logic              busy,
    input logic              cmd_reject,
    input logic              mode_valid,
    input logic              mode_err,
    input logic [1:0]        rd_lat,
    input logic              cmd_go
);

    assert_lat_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lat <= 2'd1);

    assert_bank_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && cmd_bank != '0) |=> ($stable(mode_valid) && $stable(mode_err) && $stable(rd_lat)));

    assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_rd || cmd_wr) && !mode_valid) |=> (cmd_reject && !busy));

    assert_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> (busy && col_out == $past(cmd_col)));

    assert_busy_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mode_valid);

    assert_block_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(cmd_go)) |-> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_load  (cmd_load),
    .cmd_bank  (cmd_bank),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_col   (cmd_col),
    .col_out   (col_out),
    .busy      (busy),
    .cmd_reject(cmd_reject),
    .mode_valid(mode_valid),
    .mode_err  (mode_err),
    .rd_lat    (rd_lat),
    .cmd_go    (cmd_go)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;

    localparam int COL_W  = 6;
    localparam int MODE_W = 13;
    localparam int BANK_W = 2;
    localparam int CLK_P  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_load = 1'b0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [MODE_W-1:0] cmd_addr = '0;
    logic              cmd_rd = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [COL_W-1:0]  col_out;
    logic              busy, beat_write, cmd_reject, mode_valid, mode_err;
    logic [1:0]        rd_lat;

    int checks = 0;
    int errors = 0;

    // bench-side mode model
    bit m_valid = 0;
    int m_len   = 2;
    bit m_itlv  = 0;
    int m_lat   = 0;
    bit m_err   = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W), .BANK_W(BANK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
        .col_out(col_out), .busy(busy), .beat_write(beat_write),
        .cmd_reject(cmd_reject), .mode_valid(mode_valid), .mode_err(mode_err),
        .rd_lat(rd_lat)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int st, int i, int len, bit il);
        int mask = len - 1;
        int low  = il ? ((st ^ i) & mask) : ((st + i) & mask);
        return ((st & ~mask) | low) & ((1 << COL_W) - 1);
    endfunction

    function automatic logic [MODE_W-1:0] mk_word(int len_c, bit il, int lat_c, int op);
        return MODE_W'((op << 7) | (lat_c << 4) | (int'(il) << 3) | len_c);
    endfunction

    // bench decode of a load, from the requirement encodings
    task automatic model_load(input int bank, input logic [MODE_W-1:0] w);
        int lc = int'(w[2:0]);
        int cc = int'(w[6:4]);
        int op = int'(w[MODE_W-1:7]);
        bit ok = ((lc >= 1) && (lc <= 3)) && ((cc == 2) || (cc == 6)) && ((op == 0) || (op == 2));
        if (bank != 0) return;
        if (ok) begin
            m_valid = 1; m_len = 2 << (lc - 1); m_itlv = w[3];
            m_lat = (cc == 6) ? 1 : 0; m_err = 0;
        end else begin
            m_err = 1;
        end
    endtask

    task automatic check_mode(input string req);
        chk({req, " mode_valid"}, int'(mode_valid), int'(m_valid));
        chk({req, " mode_err"}, int'(mode_err), int'(m_err));
        chk({req, " rd_lat"}, int'(rd_lat), m_lat);
    endtask

    task automatic do_load(input int bank, input logic [MODE_W-1:0] w, input string req);
        @(negedge clk);
        cmd_load = 1'b1; cmd_bank = BANK_W'(bank); cmd_addr = w;
        @(negedge clk);
        cmd_load = 1'b0;
        model_load(bank, w);
        check_mode(req);
    endtask

    // issue a command and check n beats (n < 0: full burst and idle after)
    task automatic do_burst(input int col, input bit rd, input bit wr, input int n, input string req);
        int len = m_len;
        bit il  = m_itlv;
        int nb  = (n < 0) ? len : n;
        @(negedge clk);
        cmd_rd = rd; cmd_wr = wr; cmd_col = COL_W'(col);
        if (!m_valid) begin
            @(negedge clk);
            cmd_rd = 1'b0; cmd_wr = 1'b0;
            chk({req, " R5 reject"}, int'(cmd_reject), 1);
            chk({req, " R5 busy"}, int'(busy), 0);
            return;
        end
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            if (i == 0) begin cmd_rd = 1'b0; cmd_wr = 1'b0; end
            chk({req, " R6 busy"}, int'(busy), 1);
            chk({req, il ? " R8 col" : " R7 col"}, int'(col_out), exp_col(col, i, len, il));
            chk({req, " R9 beat_write"}, int'(beat_write), int'(wr && !rd));
        end
        if (n < 0) begin
            @(negedge clk);
            chk({req, " R6 end"}, int'(busy), 0);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 reject", int'(cmd_reject), 0);
        check_mode("R1");

        // R5 refuse before programming
        do_burst(5, 1, 0, -1, "unprog rd");
        do_burst(9, 0, 1, -1, "unprog wr");

        // R4 load to a non-base bank ignored
        do_load(1, mk_word(2, 0, 2, 0), "R4 bank1");
        do_load(3, mk_word(3, 1, 6, 0), "R4 bank3");

        // R2 legal load: 4 beats, sequential, 2 clocks
        do_load(0, mk_word(2, 0, 2, 0), "R2 len4");
        do_burst(6, 1, 0, -1, "R7 len4 wrap");
        do_burst(63, 1, 0, -1, "R7 len4 top");

        // R2 8 beats interleaved 2.5 clocks with DLL reset bit
        do_load(0, mk_word(3, 1, 6, 2), "R2 len8 dll");
        do_burst(5, 1, 0, -1, "R8 len8");
        do_burst(58, 0, 1, -1, "R9 wr len8");

        // R3 reserved codes keep the setting
        do_load(0, mk_word(0, 0, 2, 0), "R3 len000");
        do_load(0, mk_word(4, 0, 2, 0), "R3 len100");
        do_load(0, mk_word(1, 0, 3, 0), "R3 lat011");
        do_load(0, mk_word(1, 0, 2, 1), "R3 op bit7");
        do_burst(3, 1, 0, -1, "R3 kept len8");
        // R4 non-base load leaves error flag alone
        do_load(2, mk_word(1, 0, 2, 0), "R4 err held");

        // 2 beats sequential
        do_load(0, mk_word(1, 0, 2, 0), "R2 len2");
        do_burst(13, 0, 1, -1, "R9 wr len2");
        do_burst(12, 1, 1, -1, "R9 rd+wr");

        // R10 restart mid-burst
        do_load(0, mk_word(3, 0, 2, 0), "R2 len8 seq");
        do_burst(20, 1, 0, 3, "R10 first");
        do_burst(41, 0, 1, -1, "R10 second");

        // R11 load during a running burst
        @(negedge clk);
        cmd_rd = 1'b1; cmd_col = COL_W'(7);
        @(negedge clk);
        cmd_rd = 1'b0;
        cmd_load = 1'b1; cmd_bank = '0; cmd_addr = mk_word(1, 1, 6, 0);
        chk("R11 b0", int'(col_out), exp_col(7, 0, 8, 0));
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            cmd_load = 1'b0;
            chk("R11 busy", int'(busy), 1);
            chk("R11 col", int'(col_out), exp_col(7, i, 8, 0));
        end
        model_load(0, mk_word(1, 1, 6, 0));
        @(negedge clk);
        chk("R11 end", int'(busy), 0);
        check_mode("R11 new mode");
        do_burst(7, 1, 0, -1, "R11 next len2 il");

        // random mix
        for (int k = 0; k < 300; k++) begin
            int r = int'($urandom % 10);
            if (r < 3) begin
                int lc = (($urandom % 8) == 0) ? int'($urandom % 8) : 1 + int'($urandom % 3);
                int cc = (($urandom % 8) == 0) ? int'($urandom % 8) : ((($urandom % 2) == 0) ? 2 : 6);
                int op = (($urandom % 8) == 0) ? int'($urandom % 64) : ((($urandom % 4) == 0) ? 2 : 0);
                int bk = (($urandom % 6) == 0) ? 1 + int'($urandom % 3) : 0;
                do_load(bk, mk_word(lc, 1'($urandom % 2), cc, op), "R2/R3 rnd load");
            end else begin
                bit rd = 1'($urandom % 2);
                do_burst(int'($urandom % 64), rd, ~rd, -1, "rnd burst");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule